// File: doc/BRIEF.md
# Write-Once Oscillator Mode Register

This block is an 8-bit configuration register on a simple memory-mapped bus. It selects how the two high-speed clock pins behave and picks the gain range of the oscillator. After a reset, software may write it exactly once. From then on it is frozen until the next reset. It can be read back at any time.

Two mode bits choose one of three pin configurations:
- both pins as general input ports,
- both pins dedicated to a crystal or resonator,
- the second pin taking an external clock while the first stays an input port.

A gain bit chooses between the low and the high frequency range of the oscillator. The decoded pin configuration reaches the pin multiplexers only while the oscillator reports that it is stopped. If software writes the register while the oscillator runs, the stored byte changes at once. The pins keep their old configuration until the stop status is seen. The gain select follows the stored byte directly.

Top module: `osc_mode_reg`

## Requirements
- R1: After reset the stored byte is 00H, a read returns 00H, the port-mode output is 1, the crystal-mode and external-clock outputs are 0, and the high-gain output is 0.
- R2: A write with the write strobe high, the address equal to 20'hFFFA0 and the byte-size qualifier high is accepted if it is the first accepted write since reset. It stores the write data with bits 5 to 1 forced to 0.
- R3: Once one write has been accepted, every later write leaves the stored byte unchanged until the next reset.
- R4: A write with the byte-size qualifier low changes nothing and does not use up the single permitted write.
- R5: A write or read at any address other than 20'hFFFA0 has no effect on the register, and its read data is 00H.
- R6: Bits 5 to 1 of the stored byte always read back as 0, even when written as 1.
- R7: The pin-mode outputs decode the mode pair {bit 7, bit 6}. The values 00 and 10 give port mode, 01 gives crystal mode and 11 gives external-clock mode. Exactly one of the three outputs is high at any time.
- R8: The high-gain output equals bit 0 of the stored byte: 0 selects the 1 to 10 MHz range and 1 selects the range above 10 MHz up to 20 MHz.
- R9: The pin-mode outputs change only on a clock edge at which the stop-status input is high. At such an edge they take the decode of the byte stored at that same edge. While stop-status is low they hold their value.
- R10: An accepted write of 00H still uses up the single permitted write.
- R11: A read with the read strobe high, a matching address and the byte-size qualifier high returns the stored byte on the read-data port in the same cycle. The read data is 00H otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 20 | Access address |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busByte | input | 1 | High for a full 8-bit access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| oscStopped | input | 1 | High while the oscillator is stopped |
| pinPortMode | output | 1 | Both pins act as input ports |
| pinXtalMode | output | 1 | Pins drive the crystal/resonator |
| pinExtClkMode | output | 1 | Second pin takes an external clock |
| oscHighGain | output | 1 | High-frequency gain range select |

## Verification
Four properties are checked on every cycle:
- exactly one pin mode is active,
- the reserved bits stay zero,
- the stored byte is frozen once the lock is taken, and a narrow write changes neither the byte nor the lock,
- the pin modes hold across any edge where the oscillator runs.

The bench scenarios show the rest. They check the exact decode of every one of the 256 written values and that only the first write takes effect. They also check that a write of zero still takes the lock, that other addresses are ignored, and that the pin mode is adopted on the first edge at which the stop status appears.

// File: rtl/osc_mode_pkg.sv
package osc_mode_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 20;
  localparam logic [ADDR_W-1:0] REG_ADDR = 20'hFFFA0;
  localparam int EXT_BIT  = 7;
  localparam int OSC_BIT  = 6;
  localparam int GAIN_BIT = 0;
  localparam logic [DATA_W-1:0] KEEP_MASK =
    DATA_W'((1 << EXT_BIT) | (1 << OSC_BIT) | (1 << GAIN_BIT));

  typedef enum logic [1:0] {
    MODE_PORT   = 2'd0,
    MODE_XTAL   = 2'd1,
    MODE_EXTCLK = 2'd2
  } pin_mode_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } reg_strobe_t;

  function automatic pin_mode_e decodeMode(input logic [DATA_W-1:0] v);
    case ({v[EXT_BIT], v[OSC_BIT]})
      2'b01:   return MODE_XTAL;
      2'b11:   return MODE_EXTCLK;
      default: return MODE_PORT;
    endcase
  endfunction
endpackage

// File: rtl/osc_mode_ctrl.sv
module osc_mode_ctrl
  import osc_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              busByte,
  output reg_strobe_t       stb,
  output logic              locked
);
  logic hit;

  assign hit      = (busAddr == REG_ADDR) && busByte;
  assign stb.wrEn = hit && busWe && !locked;
  assign stb.rdEn = hit && busRe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         locked <= 1'b0;
    else if (stb.wrEn) locked <= 1'b1;
  end
endmodule

// File: rtl/osc_mode_dp.sv
module osc_mode_dp
  import osc_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  reg_strobe_t       stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              oscStopped,
  output logic [DATA_W-1:0] regVal,
  output logic [DATA_W-1:0] rdData,
  output pin_mode_e         activeMode
);
  logic [DATA_W-1:0] nextVal;

  assign nextVal = stb.wrEn ? (wrData & KEEP_MASK) : regVal;
  assign rdData  = stb.rdEn ? regVal : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regVal     <= '0;
      activeMode <= MODE_PORT;
    end else begin
      regVal <= nextVal;
      if (oscStopped) activeMode <= decodeMode(nextVal);
    end
  end
endmodule

// File: rtl/osc_mode_reg.sv
module osc_mode_reg
  import osc_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [19:0] busAddr,
  input  logic        busWe,
  input  logic        busRe,
  input  logic        busByte,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  input  logic        oscStopped,
  output logic        pinPortMode,
  output logic        pinXtalMode,
  output logic        pinExtClkMode,
  output logic        oscHighGain
);
  reg_strobe_t stb;
  logic        locked;
  logic [7:0]  regVal;
  pin_mode_e   activeMode;

  osc_mode_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .busByte(busByte), .stb(stb), .locked(locked)
  );

  osc_mode_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWdata),
    .oscStopped(oscStopped), .regVal(regVal), .rdData(busRdata),
    .activeMode(activeMode)
  );

  assign pinPortMode   = (activeMode == MODE_PORT);
  assign pinXtalMode   = (activeMode == MODE_XTAL);
  assign pinExtClkMode = (activeMode == MODE_EXTCLK);
  assign oscHighGain   = regVal[GAIN_BIT];
endmodule

// File: rtl/osc_mode_chk.sv
module osc_mode_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busWe,
  input logic       busByte,
  input logic       oscStopped,
  input logic       locked,
  input logic [7:0] regVal,
  input logic       pinPortMode,
  input logic       pinXtalMode,
  input logic       pinExtClkMode
);
  logic [2:0] modeVec;
  assign modeVec = {pinPortMode, pinXtalMode, pinExtClkMode};

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(modeVec) == 1); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regVal[5:1] == 5'd0); // R6
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(regVal)); // R3
  AST_NARROW_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !busByte) |=> ($stable(regVal) && $stable(locked))); // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !oscStopped |=> $stable(modeVec)); // R9
endmodule

bind osc_mode_reg osc_mode_chk chk_i (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busByte(busByte),
  .oscStopped(oscStopped), .locked(locked), .regVal(regVal),
  .pinPortMode(pinPortMode), .pinXtalMode(pinXtalMode),
  .pinExtClkMode(pinExtClkMode)
);

// File: tb/osc_mode_reg_tb.sv
module osc_mode_reg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0, busByte = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        oscStopped = 1'b1;
  logic        pinPortMode, pinXtalMode, pinExtClkMode, oscHighGain;
  int          nTests = 0, nFails = 0;
  bit          done = 1'b0;

  localparam logic [19:0] ADDR = 20'hFFFA0;

  always #2.5 clk = ~clk;

  osc_mode_reg dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busByte(busByte), .busWdata(busWdata), .busRdata(busRdata),
    .oscStopped(oscStopped), .pinPortMode(pinPortMode),
    .pinXtalMode(pinXtalMode), .pinExtClkMode(pinExtClkMode),
    .oscHighGain(oscHighGain)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    busWe = 0; busRe = 0; busByte = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doWrite(input logic [19:0] a, input logic [7:0] d, input logic full);
    @(negedge clk);
    busAddr = a; busWdata = d; busByte = full; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busByte = 1'b0;
  endtask

  task automatic doRead(input logic [19:0] a, input logic full, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busByte = full; busRe = 1'b1;
    #1 d = busRdata;
    busRe = 1'b0; busByte = 1'b0;
  endtask

  function automatic logic [2:0] expMode(input logic [7:0] v);
    case (v[7:6])
      2'b01:   return 3'b010;
      2'b11:   return 3'b001;
      default: return 3'b100;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++; nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    doReset();
    doRead(ADDR, 1'b1, rd);
    check("R1 readback", rd, 8'h00);
    check("R1 modes", {pinPortMode, pinXtalMode, pinExtClkMode}, 3'b100);
    check("R1 gain", oscHighGain, 1'b0);

    // Exhaustive sweep over every written value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] exp;
      exp = 8'(v) & 8'hC1;
      doReset();
      oscStopped = 1'b1;
      doWrite(ADDR, 8'(v), 1'b1);
      doRead(ADDR, 1'b1, rd);
      check("R2 R6 stored", rd, exp);
      check("R7 decode", {pinPortMode, pinXtalMode, pinExtClkMode}, expMode(exp));
      check("R8 gain", oscHighGain, exp[0]);
      doWrite(ADDR, ~8'(v), 1'b1);
      doRead(ADDR, 1'b1, rd);
      check("R3 second write ignored", rd, exp);
      check("R3 modes kept", {pinPortMode, pinXtalMode, pinExtClkMode}, expMode(exp));
    end

    // R4: narrow write ignored, lock kept free
    doReset();
    doWrite(ADDR, 8'hC1, 1'b0);
    doRead(ADDR, 1'b1, rd);
    check("R4 narrow ignored", rd, 8'h00);
    doWrite(ADDR, 8'h41, 1'b1);
    doRead(ADDR, 1'b1, rd);
    check("R4 lock not consumed", rd, 8'h41);
    doRead(ADDR, 1'b0, rd);
    check("R11 narrow read zero", rd, 8'h00);

    // R5: other address
    doReset();
    doWrite(20'hFFFA1, 8'hC1, 1'b1);
    doWrite(20'h7FFA0, 8'h41, 1'b1);
    doRead(ADDR, 1'b1, rd);
    check("R5 foreign write ignored", rd, 8'h00);
    doWrite(ADDR, 8'h81, 1'b1);
    doRead(20'hFFFA1, 1'b1, rd);
    check("R5 foreign read zero", rd, 8'h00);
    doRead(ADDR, 1'b1, rd);
    check("R11 read returns stored", rd, 8'h81);
    #1 check("R11 idle rdata zero", busRdata, 8'h00);

    // R10: write of zero takes the lock
    doReset();
    doWrite(ADDR, 8'h00, 1'b1);
    doWrite(ADDR, 8'hC1, 1'b1);
    doRead(ADDR, 1'b1, rd);
    check("R10 zero write locks", rd, 8'h00);
    check("R10 gain", oscHighGain, 1'b0);

    // R9: mode waits for stop status
    doReset();
    oscStopped = 1'b0;
    doWrite(ADDR, 8'h41, 1'b1);
    doRead(ADDR, 1'b1, rd);
    check("R9 stored at once", rd, 8'h41);
    check("R9 gain at once", oscHighGain, 1'b1);
    check("R9 mode held", {pinPortMode, pinXtalMode, pinExtClkMode}, 3'b100);
    repeat (5) @(negedge clk);
    check("R9 mode still held", {pinPortMode, pinXtalMode, pinExtClkMode}, 3'b100);
    oscStopped = 1'b1;
    @(negedge clk);
    check("R9 mode adopted", {pinPortMode, pinXtalMode, pinExtClkMode}, 3'b010);
    oscStopped = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 mode kept when running", {pinPortMode, pinXtalMode, pinExtClkMode}, 3'b010);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule